// File: doc/BRIEF.md
# Precision Time-of-Day Clock with Rate Trim

This block keeps a running time of day as a seconds count and a nanoseconds count. The nanoseconds count grows by a fixed nominal period on every clock cycle. When it reaches one billion it wraps, and the carry goes into the seconds count. Software reaches the clock through a small register port. It stages a time or an offset in three access registers, then writes an action code. The action code either copies the running time into the access registers, overwrites the running time with them, or shifts the running time by a signed nanosecond offset.

A rate trimmer sits beside the counter. It measures elapsed time in picoseconds or nanoseconds against a programmed interval. Each time the interval is used up, it makes that cycle's increment one nanosecond longer or shorter. This lets software pull the clock's rate without stepping it.

A backward offset can leave the clock a few nanoseconds short of the current second. The nanoseconds field then holds a small negative value, wrapped in 30 bits. The counter runs on through zero by itself, with no second change. The register port is plain control: a write is accepted on any cycle where `wr_en` is high, reads are combinational, and there is no back-pressure.

Top module: `ptp_tod_clock`

## Requirements
- R1: After reset, the time outputs and every readable register are zero, and the held action code is IDLE.
- R2: With no action and trim disabled, `tod_ns` grows by NOM_NS on each cycle. Reaching 1,000,000,000 subtracts that amount and adds one to `tod_sec`, carrying across the 32-bit word boundary.
- R3: Writing code 1 (SAVE) to address 0 copies the time held before that edge into the access registers in one edge. The copy goes to seconds bits 31:0 at address 1, seconds bits 47:32 at address 2 and nanoseconds at address 3. The running time keeps advancing.
- R4: Writing code 2 (LOAD) makes the time outputs equal the access seconds and nanoseconds right after the accepting edge.
- R5: Writing code 3 (DELTA) sets the time to the pre-edge value plus NOM_NS plus the 30-bit two's-complement offset at address 3. A result of one billion or more carries into the seconds. A result below -16 borrows from the seconds. Offsets are defined for magnitudes below half a second.
- R6: A DELTA result from -16 to -1 is held as 2^30 plus that value, with the seconds unchanged. A SAVE taken then captures the wrapped value. The next increments pass through zero with no seconds change.
- R7: Code 0 (IDLE) does nothing. Writing the code that is already held does nothing, so each action takes effect once.
- R8: Address 4 holds the trim interval in bits 29:0 and the unit in bit 30 (1 = nanoseconds, 0 = picoseconds). Address 5 holds enable in bit 0 and subtract in bit 1. Address 2 reads back only 16 bits. Unmapped addresses read zero.
- R9: With trim enabled, each cycle adds NOM_NS (or NOM_NS*1000 ps) to an elapsed count. On the cycle the count reaches the interval, the increment becomes NOM_NS+1 (or NOM_NS-1 when subtracting) and the count restarts. Corrections therefore fall every ceil(interval/step) cycles.
- R10: With enable at zero, no correction is made. Any write to address 4 or 5 restarts the elapsed count and suppresses a correction on that edge.
- R11: A LOAD on a correction cycle yields exactly the loaded value. A DELTA on a correction cycle includes the ±1 ns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Combinational read data |
| tod_sec | output | SEC_W | Running seconds |
| tod_ns | output | 30 | Running nanoseconds, possibly wrapped negative |

## Verification
The two functions that can fall on the same edge are the rate trimmer's ±1 ns correction and a LOAD or DELTA action. After a restarting write to address 5, the bench counts edges so that a LOAD and later a DELTA land exactly on the fifth edge of a 40 ns interval. It judges the result arithmetically: the loaded value must show no trace of the correction, and the stepped value must include it. A wrapped negative nanoseconds value followed at once by a SAVE is also provoked, and is checked against the wrapped encoding.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;
  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_SAVE  = 2'd1,
    ACT_LOAD  = 2'd2,
    ACT_DELTA = 2'd3
  } tod_act_e;

  localparam logic [2:0] A_ACT   = 3'd0;
  localparam logic [2:0] A_SECLO = 3'd1;
  localparam logic [2:0] A_SECHI = 3'd2;
  localparam logic [2:0] A_NSEC  = 3'd3;
  localparam logic [2:0] A_RATE  = 3'd4;
  localparam logic [2:0] A_TRIM  = 3'd5;

  localparam int NS_W = 30;
  localparam logic signed [31:0] BILLION   = 32'sd1000000000;
  localparam logic signed [31:0] NEG_FLOOR = -32'sd16;
  localparam logic [NS_W-1:0]    WRAP_LO   = 30'h3FFF_FFF0;
endpackage

// File: rtl/ptp_access_regs.sv
module ptp_access_regs
  import ptp_tod_pkg::*;
#(
  parameter int SEC_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [2:0]        rd_addr,
  input  logic [SEC_W-1:0]  cur_sec,
  input  logic [NS_W-1:0]   cur_ns,
  output logic [31:0]       rd_data,
  output logic [SEC_W-1:0]  acc_sec,
  output logic [NS_W-1:0]   acc_ns,
  output logic              go_save,
  output logic              go_load,
  output logic              go_delta,
  output logic              rate_unit_ns,
  output logic [NS_W-1:0]   rate_intv,
  output logic              trim_en,
  output logic              trim_sub,
  output logic              trim_restart
);
  localparam int HI_W = SEC_W - 32;

  tod_act_e act_q;
  tod_act_e code;
  logic     new_cmd;

  assign code    = tod_act_e'(wr_data[1:0]);
  assign new_cmd = wr_en && (wr_addr == A_ACT) && (code != ACT_IDLE) && (code != act_q);
  assign go_save  = new_cmd && (code == ACT_SAVE);
  assign go_load  = new_cmd && (code == ACT_LOAD);
  assign go_delta = new_cmd && (code == ACT_DELTA);
  assign trim_restart = wr_en && ((wr_addr == A_RATE) || (wr_addr == A_TRIM));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q        <= ACT_IDLE;
      acc_sec      <= '0;
      acc_ns       <= '0;
      rate_unit_ns <= 1'b0;
      rate_intv    <= '0;
      trim_en      <= 1'b0;
      trim_sub     <= 1'b0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          A_ACT:  act_q <= code;
          A_RATE: begin
            rate_intv    <= wr_data[NS_W-1:0];
            rate_unit_ns <= wr_data[30];
          end
          A_TRIM: begin
            trim_en  <= wr_data[0];
            trim_sub <= wr_data[1];
          end
          default: ;
        endcase
      end
      if (go_save) begin
        acc_sec <= cur_sec;
        acc_ns  <= cur_ns;
      end else if (wr_en) begin
        case (wr_addr)
          A_SECLO: acc_sec[31:0]       <= wr_data;
          A_SECHI: acc_sec[SEC_W-1:32] <= wr_data[HI_W-1:0];
          A_NSEC:  acc_ns              <= wr_data[NS_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (rd_addr)
      A_ACT:   rd_data = {30'd0, act_q};
      A_SECLO: rd_data = acc_sec[31:0];
      A_SECHI: rd_data = 32'(acc_sec[SEC_W-1:32]);
      A_NSEC:  rd_data = {2'b00, acc_ns};
      A_RATE:  rd_data = {1'b0, rate_unit_ns, rate_intv};
      A_TRIM:  rd_data = {30'd0, trim_sub, trim_en};
      default: rd_data = 32'd0;
    endcase
  end

  // R3
  save_snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_save |=> (acc_sec == $past(cur_sec)) && (acc_ns == $past(cur_ns)));
endmodule

// File: rtl/ptp_rate_trim.sv
module ptp_rate_trim
  import ptp_tod_pkg::*;
#(
  parameter int NOM_NS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            unit_ns,
  input  logic [NS_W-1:0] intv,
  input  logic            en,
  input  logic            restart,
  output logic            corr
);
  localparam int ACC_W = 32;
  localparam logic [ACC_W-1:0] INC_NS = ACC_W'(NOM_NS);
  localparam logic [ACC_W-1:0] INC_PS = ACC_W'(NOM_NS * 1000);

  logic [ACC_W-1:0] acc_q, sum, limit;

  assign limit = {2'b00, intv};
  assign sum   = acc_q + (unit_ns ? INC_NS : INC_PS);
  assign corr  = en && !restart && (sum >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   acc_q <= '0;
    else if (restart || !en || corr) acc_q <= '0;
    else                          acc_q <= sum;
  end

  // R9
  acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q < limit) || (acc_q == '0));
endmodule

// File: rtl/ptp_tod_core.sv
module ptp_tod_core
  import ptp_tod_pkg::*;
#(
  parameter int SEC_W  = 48,
  parameter int NOM_NS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_load,
  input  logic             go_delta,
  input  logic [SEC_W-1:0] acc_sec,
  input  logic [NS_W-1:0]  acc_ns,
  input  logic             corr,
  input  logic             corr_sub,
  output logic [SEC_W-1:0] tod_sec,
  output logic [NS_W-1:0]  tod_ns
);
  localparam logic [SEC_W-1:0] SEC_ONE = SEC_W'(1);
  localparam logic signed [31:0] STEP_NOM = 32'(NOM_NS);

  logic [SEC_W-1:0]   sec_q, sec_n;
  logic [NS_W-1:0]    ns_q, ns_n;
  logic signed [31:0] cur_v, step_v, dlt_v, sum_v;
  logic               live_q;

  assign cur_v  = (ns_q >= WRAP_LO) ? $signed({2'b11, ns_q}) : $signed({2'b00, ns_q});
  assign step_v = corr ? (corr_sub ? STEP_NOM - 32'sd1 : STEP_NOM + 32'sd1) : STEP_NOM;
  assign dlt_v  = go_delta ? $signed({{2{acc_ns[NS_W-1]}}, acc_ns}) : 32'sd0;
  assign sum_v  = cur_v + step_v + dlt_v;

  always_comb begin
    sec_n = sec_q;
    ns_n  = sum_v[NS_W-1:0];
    if (go_load) begin
      sec_n = acc_sec;
      ns_n  = acc_ns;
    end else if (sum_v >= BILLION) begin
      sec_n = sec_q + SEC_ONE;
      ns_n  = NS_W'(sum_v - BILLION);
    end else if (sum_v < NEG_FLOOR) begin
      sec_n = sec_q - SEC_ONE;
      ns_n  = NS_W'(sum_v + BILLION);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= '0;
      ns_q   <= '0;
      live_q <= 1'b0;
    end else begin
      sec_q  <= sec_n;
      ns_q   <= ns_n;
      live_q <= 1'b1;
    end
  end

  assign tod_sec = sec_q;
  assign tod_ns  = ns_q;

  // R4
  load_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_load |=> (tod_sec == $past(acc_sec)) && (tod_ns == $past(acc_ns)));

  // R6
  ns_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && !$past(go_load)) |-> ((tod_ns < 30'd1000000000) || (tod_ns >= WRAP_LO)));

  // R2
  free_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && !$past(go_load) && !$past(go_delta) && !$past(corr)) |->
      ((tod_ns == NS_W'($past(tod_ns) + NS_W'(NOM_NS))) ||
       ((tod_sec == $past(tod_sec) + SEC_ONE) &&
        (32'(tod_ns) + 32'd1000000000 == 32'($past(tod_ns)) + 32'(NOM_NS)))));
endmodule

// File: rtl/ptp_tod_clock.sv
module ptp_tod_clock
  import ptp_tod_pkg::*;
#(
  parameter int SEC_W  = 48,
  parameter int NOM_NS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [31:0]      wr_data,
  input  logic [2:0]       rd_addr,
  output logic [31:0]      rd_data,
  output logic [SEC_W-1:0] tod_sec,
  output logic [NS_W-1:0]  tod_ns
);
  logic [SEC_W-1:0] acc_sec;
  logic [NS_W-1:0]  acc_ns, rate_intv;
  logic go_save, go_load, go_delta;
  logic rate_unit_ns, trim_en, trim_sub, trim_restart, corr;

  ptp_access_regs #(.SEC_W(SEC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .cur_sec(tod_sec), .cur_ns(tod_ns), .rd_data(rd_data),
    .acc_sec(acc_sec), .acc_ns(acc_ns), .go_save(go_save), .go_load(go_load),
    .go_delta(go_delta), .rate_unit_ns(rate_unit_ns), .rate_intv(rate_intv),
    .trim_en(trim_en), .trim_sub(trim_sub), .trim_restart(trim_restart)
  );

  ptp_rate_trim #(.NOM_NS(NOM_NS)) u_trim (
    .clk(clk), .rst_n(rst_n), .unit_ns(rate_unit_ns), .intv(rate_intv),
    .en(trim_en), .restart(trim_restart), .corr(corr)
  );

  ptp_tod_core #(.SEC_W(SEC_W), .NOM_NS(NOM_NS)) u_core (
    .clk(clk), .rst_n(rst_n), .go_load(go_load), .go_delta(go_delta),
    .acc_sec(acc_sec), .acc_ns(acc_ns), .corr(corr), .corr_sub(trim_sub),
    .tod_sec(tod_sec), .tod_ns(tod_ns)
  );

  // R7
  single_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({go_save, go_load, go_delta}));
endmodule

// File: tb/ptp_tod_clock_test.sv
module ptp_tod_clock_test;
  localparam int SEC_W = 48;
  localparam longint BIL = 64'd1000000000;
  localparam longint TWO30 = 64'd1073741824;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic [SEC_W-1:0] tod_sec;
  logic [29:0] tod_ns;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ptp_tod_clock #(.SEC_W(SEC_W), .NOM_NS(8)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tod_sec(tod_sec), .tod_ns(tod_ns)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    rd_addr = a; #1; v = rd_data;
  endtask

  task automatic load_time(input longint sec, input longint ns);
    wr(3'd0, 32'd0);
    wr(3'd1, sec[31:0]);
    wr(3'd2, 32'(sec[47:32]));
    wr(3'd3, ns[31:0]);
    wr(3'd0, 32'd2);
  endtask

  task automatic run_delta(input longint sec, input longint ns0, input longint dl);
    longint v, es, en;
    load_time(sec, ns0);
    wr(3'd0, 32'd0);
    wr(3'd3, {2'b00, dl[29:0]});
    wr(3'd0, 32'd3);
    v = ns0 + 24 + dl; es = sec;
    if (v >= BIL) begin v -= BIL; es++; end
    else if (v < -16) begin v += BIL; es--; end
    en = (v < 0) ? v + TWO30 : v;
    chk("R5 delta sec", longint'(tod_sec), es);
    chk("R5 R6 delta ns", longint'(tod_ns), en);
  endtask

  task automatic run_trim(input bit unit_ns, input longint intv, input bit sub);
    longint a, inc, per, e;
    load_time(1, 0);
    wr(3'd4, {1'b0, unit_ns, intv[29:0]});
    wr(3'd5, {30'd0, sub, 1'b1});
    a = longint'(tod_ns);
    inc = unit_ns ? 8 : 8000;
    per = (intv + inc - 1) / inc;
    for (int k = 1; k <= 12; k++) begin
      idle(1);
      e = a + 8 * k + (sub ? -(k / per) : (k / per));
      chk("R9 trim ns", longint'(tod_ns), e);
    end
    wr(3'd5, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    longint a, s_sec, s_ns;
    longint dsec [7] = '{7, 7, 7, 9, 9, 3, 64'h1_0000_0000};
    longint dns  [7] = '{100, 100, 100, 999999000, 500, 250000000, 10};
    longint doff [7] = '{-132, -124, -141, 2000, -400000000, 499999999, -100};

    idle(3);
    // R1 reset state
    chk("R1 sec", longint'(tod_sec), 0);
    chk("R1 ns", longint'(tod_ns), 0);
    for (int ad = 0; ad < 8; ad++) begin
      rd(3'(ad), r);
      chk("R1 reg", longint'(r), 0);
    end
    rst_n = 1'b1;
    idle(1);

    // R2 free run
    a = longint'(tod_ns);
    idle(10);
    chk("R2 free run", longint'(tod_ns), a + 80);

    // R4 load, R2 carry across word boundary
    load_time(64'h1234_FFFF_FFFF, 999999992);
    chk("R4 load sec", longint'(tod_sec), 64'h1234_FFFF_FFFF);
    chk("R4 load ns", longint'(tod_ns), 999999992);
    idle(1);
    chk("R2 carry sec", longint'(tod_sec), 64'h1235_0000_0000);
    chk("R2 carry ns", longint'(tod_ns), 0);
    for (int k = 0; k < 8; k++) begin
      load_time(500 + k, BIL - 8 - k);
      idle(2);
      chk("R2 roll sec", longint'(tod_sec), 501 + k);
      chk("R2 roll ns", longint'(tod_ns), 8 - k);
    end

    // R3 save
    wr(3'd0, 32'd0);
    s_sec = longint'(tod_sec); s_ns = longint'(tod_ns);
    wr(3'd0, 32'd1);
    chk("R3 running", longint'(tod_ns), s_ns + 8);
    rd(3'd1, r); chk("R3 sec lo", longint'(r), s_sec & 64'hFFFF_FFFF);
    rd(3'd2, r); chk("R3 sec hi", longint'(r), s_sec >> 32);
    rd(3'd3, r); chk("R3 ns", longint'(r), s_ns);

    // R7 repeated code and IDLE
    idle(3);
    wr(3'd0, 32'd1);
    rd(3'd3, r); chk("R7 repeat save ignored", longint'(r), s_ns);
    a = longint'(tod_ns);
    wr(3'd0, 32'd0);
    chk("R7 idle no effect", longint'(tod_ns), a + 8);

    // R8 register map
    wr(3'd4, 32'h4000_0028);
    rd(3'd4, r); chk("R8 rate", longint'(r), 32'h4000_0028);
    wr(3'd5, 32'd3);
    rd(3'd5, r); chk("R8 trim cfg", longint'(r), 3);
    wr(3'd5, 32'd0);
    wr(3'd2, 32'hFFFF_ABCD);
    rd(3'd2, r); chk("R8 sec hi width", longint'(r), 32'h0000_ABCD);
    rd(3'd7, r); chk("R8 unmapped", longint'(r), 0);
    rd(3'd0, r); chk("R8 action readback", longint'(r), 0);

    // R5 / R6 delta sweep
    for (int i = 0; i < 7; i++) run_delta(dsec[i], dns[i], doff[i]);

    // R6 wrapped value captured by SAVE, then passes zero
    run_delta(7, 100, -140);
    wr(3'd0, 32'd1);
    rd(3'd3, r); chk("R6 save wrapped ns", longint'(r), 32'h3FFF_FFF0);
    rd(3'd1, r); chk("R6 save wrapped sec", longint'(r), 7);
    chk("R6 still wrapped", longint'(tod_ns), 32'h3FFF_FFF8);
    idle(1);
    chk("R6 through zero ns", longint'(tod_ns), 0);
    chk("R6 through zero sec", longint'(tod_sec), 7);

    // R9 trim sweep
    run_trim(1'b1, 8, 1'b0);
    run_trim(1'b1, 16, 1'b0);
    run_trim(1'b1, 40, 1'b1);
    run_trim(1'b1, 41, 1'b0);
    run_trim(1'b0, 8000, 1'b0);
    run_trim(1'b0, 24000, 1'b1);
    run_trim(1'b0, 25000, 1'b0);

    // R10 disabled and restart
    load_time(1, 0);
    wr(3'd4, 32'h4000_0028);
    wr(3'd5, 32'd0);
    a = longint'(tod_ns);
    idle(20);
    chk("R10 disabled", longint'(tod_ns), a + 160);
    wr(3'd5, 32'd1);
    a = longint'(tod_ns);
    idle(3);
    wr(3'd5, 32'd1);
    idle(1);
    chk("R10 restart no early corr", longint'(tod_ns), a + 40);
    idle(4);
    chk("R10 restart corr", longint'(tod_ns), a + 73);

    // R11 collisions with the correction edge
    wr(3'd5, 32'd1);
    wr(3'd0, 32'd0);
    wr(3'd3, 32'd1000);
    idle(2);
    wr(3'd0, 32'd2);
    chk("R11 load on corr", longint'(tod_ns), 1000);
    wr(3'd0, 32'd0);
    wr(3'd3, 32'd500);
    idle(2);
    wr(3'd0, 32'd3);
    chk("R11 delta on corr", longint'(tod_ns), 1541);
    wr(3'd5, 32'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule